// File: doc/BRIEF.md
# Burst Memory Command Decoder

This block sits at the control edge of a synchronous burst memory. On every rising clock edge it looks at two address strobes, three chip selects, a burst-step input and the write enables, and decides what kind of cycle the memory performs. The memory array, the burst address arithmetic and the data output drivers are outside this block. They are driven by the registered results: an address-load strobe, a burst-step strobe, a per-lane write mask with the captured write data, a chip-active flag and a cycle-kind code.

The first strobe belongs to the processor. It is honoured only while the main chip select is active, and it always opens a read. The second strobe belongs to the controller. It takes effect only when the processor strobe is not in effect, and it samples the write enables on the same edge, so a cycle it opens can start as a write. When neither strobe is in effect and a burst is open, the step input either moves the burst on or holds it at the current address. The write enables are sampled on that edge as well.

All results are registered on the edge that samples the inputs.

Top module: `burst_cmd_decoder`

## Requirements
- R1: After reset, every output is zero and the cycle kind reads IDLE. The cycle-kind encodings are IDLE=0, DESEL=1, RD_START=2, WR_START=3, RD_STEP=4, WR_STEP=5, RD_HOLD=6 and WR_HOLD=7.
- R2: Suppose the processor strobe is low, the main select is low, sel_hi is high and sel_lo_n is low. The cycle is then RD_START with load_addr=1, chip_active=1 and wr_mask=0. The write enables and the controller strobe do not change this.
- R3: When the main select is high, the processor strobe is ignored. With the controller strobe high, the cycle continues or holds the open burst. With the controller strobe low, the cycle is a DESEL.
- R4: Suppose the controller strobe is low, the processor strobe is not in effect and all three selects are active. The cycle is then WR_START with load_addr=1 when any lane is written, and RD_START with load_addr=1 otherwise.
- R5: A strobe that is in effect while any select is inactive gives DESEL, chip_active=0, load_addr=0 and wr_mask=0.
- R6: A low wr_all_n on a write-capable edge sets every bit of wr_mask, whatever wr_lanes_n holds.
- R7: With wr_all_n high and wr_byte_en_n low, wr_mask[i]=1 exactly for each lane whose wr_lanes_n[i] is low. With wr_byte_en_n high, or with no lane low, the cycle is a read with wr_mask=0.
- R8: Suppose no strobe is in effect and a burst is open. A low adv_n gives adv_step=1 and a STEP kind. A high adv_n gives adv_step=0 and a HOLD kind, and a write on a HOLD still applies its mask.
- R9: With no strobe in effect and no burst open, the cycle is IDLE with adv_step=0 and wr_mask=0.
- R10: wr_data_q takes wr_data on the same edge that produces a nonzero wr_mask. Otherwise it keeps its value.
- R11: adv_step is 0 on every edge that loads an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| sel_main_n | input | 1 | Main chip select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst step request, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_byte_en_n | input | 1 | Enables the per-lane write inputs, active low |
| wr_lanes_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | LANES*LANE_W | Write data |
| load_addr | output | 1 | Load external address this cycle |
| adv_step | output | 1 | Step burst address |
| wr_mask | output | LANES | Lanes written at the array port |
| wr_data_q | output | LANES*LANE_W | Captured write data |
| chip_active | output | 1 | A burst is open |
| cyc_kind | output | 3 | Decoded cycle kind |

## Verification
The bench builds the block with LANES=4 and LANE_W=8, which is wider than the two-lane default. With four lanes it can drive sparse and single-lane masks, which show that each lane follows only its own enable, and the all-lane override. The scenarios walk one burst through load, step, hold, blocked-processor-strobe and deselect. They also cover controller-opened writes, strobe collisions, and a byte-write enable with no lane selected.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [2:0] {
    CK_IDLE     = 3'd0,
    CK_DESEL    = 3'd1,
    CK_RD_START = 3'd2,
    CK_WR_START = 3'd3,
    CK_RD_STEP  = 3'd4,
    CK_WR_STEP  = 3'd5,
    CK_RD_HOLD  = 3'd6,
    CK_WR_HOLD  = 3'd7
  } cyc_kind_t;

  typedef struct packed {
    cyc_kind_t kind;
    logic      load;
    logic      step;
    logic      write;
    logic      burst_next;
  } cyc_dec_t;
endpackage

// File: rtl/bcd_lane_mask.sv
module bcd_lane_mask #(
  parameter int LANES = 2
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] wr_lanes_n,
  output logic [LANES-1:0] lane_mask,
  output logic             any_write
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = ~wr_all_n | (~wr_byte_en_n & ~wr_lanes_n[i]);
  end
  assign any_write = |lane_mask;
endmodule

// File: rtl/bcd_classify.sv
module bcd_classify
  import bcd_pkg::*;
(
  input  logic     cpu_strobe_n,
  input  logic     ctl_strobe_n,
  input  logic     sel_main_n,
  input  logic     sel_hi,
  input  logic     sel_lo_n,
  input  logic     adv_n,
  input  logic     any_write,
  input  logic     burst_on,
  output cyc_dec_t dec
);
  logic cpu_eff;
  logic ctl_eff;
  logic sel_ok;

  always_comb begin
    // processor strobe is gated by the main select; controller strobe is not
    cpu_eff = ~cpu_strobe_n & ~sel_main_n;
    ctl_eff = ~ctl_strobe_n & ~cpu_eff;
    sel_ok  = ~sel_main_n & sel_hi & ~sel_lo_n;

    dec            = '0;
    dec.kind       = CK_IDLE;
    dec.burst_next = burst_on;

    if (cpu_eff || ctl_eff) begin
      if (!sel_ok) begin
        dec.kind       = CK_DESEL;
        dec.burst_next = 1'b0;
      end else begin
        dec.load       = 1'b1;
        dec.burst_next = 1'b1;
        // write enables count only when the controller opened the cycle
        if (ctl_eff && any_write) begin
          dec.kind  = CK_WR_START;
          dec.write = 1'b1;
        end else begin
          dec.kind  = CK_RD_START;
        end
      end
    end else if (burst_on) begin
      dec.write = any_write;
      dec.step  = ~adv_n;
      unique case ({any_write, ~adv_n})
        2'b00:   dec.kind = CK_RD_HOLD;
        2'b01:   dec.kind = CK_RD_STEP;
        2'b10:   dec.kind = CK_WR_HOLD;
        default: dec.kind = CK_WR_STEP;
      endcase
    end
  end
endmodule

// File: rtl/burst_cmd_decoder.sv
module burst_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             sel_main_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] wr_lanes_n,
  input  logic [DW-1:0]    wr_data,
  output logic             load_addr,
  output logic             adv_step,
  output logic [LANES-1:0] wr_mask,
  output logic [DW-1:0]    wr_data_q,
  output logic             chip_active,
  output logic [2:0]       cyc_kind
);
  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic [LANES-1:0] lane_mask;
  logic             any_write;
  cyc_dec_t         dec;
  logic [LANES-1:0] mask_d;
  logic             data_en;

  cyc_kind_t        kind_q;
  logic             load_q;
  logic             step_q;
  logic [LANES-1:0] mask_q;
  logic             on_q;
  logic [DW-1:0]    data_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  bcd_lane_mask #(.LANES(LANES)) u_mask (
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .wr_lanes_n   (wr_lanes_n),
    .lane_mask    (lane_mask),
    .any_write    (any_write)
  );

  bcd_classify u_cls (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .sel_main_n   (sel_main_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .adv_n        (adv_n),
    .any_write    (any_write),
    .burst_on     (on_q),
    .dec          (dec)
  );

  always_comb begin
    mask_d  = dec.write ? lane_mask : '0;
    data_en = |mask_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      kind_q <= CK_IDLE;
      load_q <= 1'b0;
      step_q <= 1'b0;
      mask_q <= '0;
      on_q   <= 1'b0;
    end else begin
      kind_q <= dec.kind;
      load_q <= dec.load;
      step_q <= dec.step;
      mask_q <= mask_d;
      on_q   <= dec.burst_next;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     data_q <= '0;
    else if (data_en) data_q <= wr_data;
  end

  assign load_addr   = load_q;
  assign adv_step    = step_q;
  assign wr_mask     = mask_q;
  assign wr_data_q   = data_q;
  assign chip_active = on_q;
  assign cyc_kind    = kind_q;
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
  parameter int LANES = 2,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             cpu_strobe_n,
  input logic             ctl_strobe_n,
  input logic             sel_main_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             load_addr,
  input logic             adv_step,
  input logic [LANES-1:0] wr_mask,
  input logic [DW-1:0]    wr_data_q,
  input logic             chip_active
);
  assert_load_no_step_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_addr |-> !adv_step);

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cpu_strobe_n && !sel_main_n && sel_hi && !sel_lo_n)
      |=> (load_addr && chip_active && wr_mask == '0));

  assert_main_blocks_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cpu_strobe_n && sel_main_n && ctl_strobe_n && chip_active)
      |=> (!load_addr && chip_active));

  assert_desel_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((!cpu_strobe_n && !sel_main_n || !ctl_strobe_n) && !(!sel_main_n && sel_hi && !sel_lo_n))
      |=> (!chip_active && !load_addr && wr_mask == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!chip_active && cpu_strobe_n && ctl_strobe_n)
      |=> (!adv_step && !load_addr && wr_mask == '0));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_mask == '0) |-> $stable(wr_data_q));
endmodule

bind burst_cmd_decoder bcd_checker #(.LANES(LANES), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .sel_main_n   (sel_main_n),
  .sel_hi       (sel_hi),
  .sel_lo_n     (sel_lo_n),
  .load_addr    (load_addr),
  .adv_step     (adv_step),
  .wr_mask      (wr_mask),
  .wr_data_q    (wr_data_q),
  .chip_active  (chip_active)
);

// File: tb/burst_cmd_decoder_test.sv
module burst_cmd_decoder_test;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cpu_strobe_n, ctl_strobe_n, sel_main_n, sel_hi, sel_lo_n, adv_n;
  logic             wr_all_n, wr_byte_en_n;
  logic [LANES-1:0] wr_lanes_n;
  logic [DW-1:0]    wr_data;
  logic             load_addr, adv_step, chip_active;
  logic [LANES-1:0] wr_mask;
  logic [DW-1:0]    wr_data_q;
  logic [2:0]       cyc_kind;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [2:0]       kind;
    logic             load;
    logic             adv;
    logic [LANES-1:0] mask;
    logic             act;
    logic [DW-1:0]    data;
    string            req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  burst_cmd_decoder #(.LANES(LANES), .LANE_W(LANE_W)) uut (.*);

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "kind",   DW'(cyc_kind),    DW'(e.kind));
      chk(e.req, "load",   DW'(load_addr),   DW'(e.load));
      chk(e.req, "adv",    DW'(adv_step),    DW'(e.adv));
      chk(e.req, "mask",   DW'(wr_mask),     DW'(e.mask));
      chk(e.req, "active", DW'(chip_active), DW'(e.act));
      chk(e.req, "data",   wr_data_q,        e.data);
    end
  end

  task automatic idle_in();
    cpu_strobe_n = 1; ctl_strobe_n = 1; sel_main_n = 0; sel_hi = 1; sel_lo_n = 0;
    adv_n = 1; wr_all_n = 1; wr_byte_en_n = 1; wr_lanes_n = '1; wr_data = '0;
  endtask

  // driver: inputs set at negedge, expectation queued after the sampling edge
  task automatic step(input logic cp, input logic ct, input logic m, input logic h, input logic l,
                      input logic a, input logic wa, input logic wb, input logic [LANES-1:0] ln,
                      input logic [DW-1:0] d, input logic [2:0] ek, input logic el, input logic ea,
                      input logic [LANES-1:0] em, input logic eact, input logic [DW-1:0] ed,
                      input string req);
    exp_t e;
    @(negedge clk);
    cpu_strobe_n = cp; ctl_strobe_n = ct; sel_main_n = m; sel_hi = h; sel_lo_n = l;
    adv_n = a; wr_all_n = wa; wr_byte_en_n = wb; wr_lanes_n = ln; wr_data = d;
    @(posedge clk);
    #1;
    e.kind = ek; e.load = el; e.adv = ea; e.mask = em; e.act = eact; e.data = ed; e.req = req;
    sb.push_back(e);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "kind",   DW'(cyc_kind), 0);
    chk("R1", "outs",   DW'({load_addr, adv_step, chip_active}), 0);
    chk("R1", "mask",   DW'(wr_mask), 0);
    chk("R1", "data",   wr_data_q, 0);

    //   cp ct m h l a wa wb lanes   data          kind ld adv mask  act data
    step(1, 1, 0, 1, 0, 0, 1, 1, 4'hF, 32'h0,        0, 0, 0, 4'h0, 0, 32'h0,        "R9 idle step ignored");
    step(0, 0, 0, 1, 0, 0, 0, 1, 4'hF, 32'hAA,       2, 1, 0, 4'h0, 1, 32'h0,        "R2 R11 cpu read wins");
    step(1, 1, 0, 1, 0, 0, 1, 0, 4'hA, 32'h11223344, 5, 0, 1, 4'h5, 1, 32'h11223344, "R7 R8 R10 lane write step");
    step(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, 32'hDEAD,     6, 0, 0, 4'h0, 1, 32'h11223344, "R8 R10 read hold");
    step(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, 32'h55,       7, 0, 0, 4'hF, 1, 32'h55,       "R6 R8 write hold all");
    step(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, 32'h0,        4, 0, 1, 4'h0, 1, 32'h55,       "R3 main blocks cpu");
    step(0, 0, 1, 1, 0, 0, 1, 1, 4'hF, 32'h0,        1, 0, 0, 4'h0, 0, 32'h55,       "R3 R5 ctl with main off");
    step(1, 1, 0, 1, 0, 0, 0, 1, 4'hF, 32'h77,       0, 0, 0, 4'h0, 0, 32'h55,       "R9 idle write ignored");
    step(1, 0, 0, 1, 0, 0, 1, 0, 4'h7, 32'h99887766, 3, 1, 0, 4'h8, 1, 32'h99887766, "R4 R7 R11 ctl write start");
    step(1, 0, 0, 1, 0, 1, 1, 1, 4'h0, 32'h1,        2, 1, 0, 4'h0, 1, 32'h99887766, "R4 R7 ctl read start");
    step(1, 0, 0, 0, 0, 1, 1, 1, 4'hF, 32'h0,        1, 0, 0, 4'h0, 0, 32'h99887766, "R5 sel_hi low");
    step(0, 1, 0, 1, 0, 1, 1, 1, 4'hF, 32'h0,        2, 1, 0, 4'h0, 1, 32'h99887766, "R2 reopen");
    step(0, 1, 0, 1, 1, 1, 0, 1, 4'hF, 32'h3,        1, 0, 0, 4'h0, 0, 32'h99887766, "R5 sel_lo_n high");
    step(1, 0, 0, 1, 0, 1, 0, 1, 4'hF, 32'h0A0B0C0D, 3, 1, 0, 4'hF, 1, 32'h0A0B0C0D, "R4 R6 ctl write all");
    step(1, 1, 0, 1, 0, 0, 1, 0, 4'hF, 32'h4,        4, 0, 1, 4'h0, 1, 32'h0A0B0C0D, "R7 no lane selected");
    step(0, 0, 0, 1, 0, 1, 1, 0, 4'h0, 32'h5,        2, 1, 0, 4'h0, 1, 32'h0A0B0C0D, "R2 ctl and lanes ignored");
    @(negedge clk) idle_in();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule